// File: doc/BRIEF.md
# Translation-Table Update Command Engine

This block maintains an on-chip table of translation entries that maps pages of a device bus window onto memory pages. It accepts one maintenance command at a time and returns a status when the command completes. There are four commands: store one entry, fetch one entry, write one value into a run of consecutive entries, and copy a run of entries from a list held in memory. The engine reads that list through a simple request/response read port.

Every command names a 64-bit table identifier and a bus address. The address is rounded down to a page boundary, and the offset of the window base is removed from it to give the entry index. Each command also carries a value (the entry, or the list address) and a page count. Every entry write sends out a notification. The notification holds the window-relative page address, the page part of the new entry, the in-page offset mask and the two permission bits, and it is flagged as a mapping when the permission bits are nonzero and as an unmapping when they are zero. If a multi-entry command hits an entry it cannot write, it stops at that entry and reports the error. Entries written before that point keep their new values.

Top module: `tce_update_engine`

## Requirements
- R1: After reset is released, `busy` stays high for ENTRY_COUNT clock edges while the engine writes zero into every entry. Reading any entry afterwards returns zero.
- R2: A command is rejected with `sts_error`=1 and writes nothing when bits 63:32 of `cmd_table_id` are nonzero or bits 31:0 differ from TABLE_ID. The status pulse appears on the second clock edge after acceptance.
- R3: The bus address is rounded down to a page. The index is (address − BUS_OFFSET) >> PAGE_SHIFT, with unsigned wrap, so an address below the window gives a huge index. An index ≥ ENTRY_COUNT gives a parameter error and leaves the table unchanged.
- R4: Store (`cmd_op`=0) writes `cmd_value` into the indexed entry. It produces one notification and a success status, both on the third edge after acceptance. `cmd_pages` is ignored.
- R5: Fetch (`cmd_op`=1) returns the indexed entry on `sts_entry` with success on the fourth edge after acceptance. `sts_entry` is zero for every other status.
- R6: Each entry write raises `evt_valid` for one cycle with the following fields: `evt_iova` = window-relative page address, `evt_paddr` = entry with its low PAGE_SHIFT bits cleared, `evt_mask` = 2^PAGE_SHIFT−1, `evt_perm` = entry bits 1:0, and `evt_map` = 1 exactly when `evt_perm` is nonzero.
- R7: Fill (`cmd_op`=2) is rejected when `cmd_pages` > ENTRY_COUNT. Otherwise it writes `cmd_value` into successive pages, one per clock edge. The status arrives with the last write.
- R8: List load (`cmd_op`=3) is rejected when `cmd_pages` > LOAD_MAX_PAGES or when `cmd_value` bits LIST_ALIGN_SHIFT−1:0 are nonzero. Entry i is requested at `cmd_value`+8·i and written to the i-th successive page. In `lst_rsp_data`, byte lane k (bits 8k+7:8k) holds the memory byte at offset k, and lane 0 is the most significant byte of the entry.
- R9: Fill and list load stop at the first page whose index is out of range and report a parameter error. That page is neither written nor fetched, and the pages written before it keep their values.
- R10: Fill or list load with `cmd_pages`=0 writes nothing and reports success on the second edge after acceptance.
- R11: A command is accepted only on an edge where `cmd_valid` is high and `busy` is low. `cmd_valid` has no effect while `busy` is high. `sts_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 store, 1 fetch, 2 fill, 3 list load |
| cmd_table_id | input | 64 | Table identifier |
| cmd_bus_addr | input | 64 | Bus address of the first page |
| cmd_value | input | 64 | Entry value, or list address for list load |
| cmd_pages | input | 32 | Page count for fill and list load |
| busy | output | 1 | Engine is clearing or executing |
| sts_valid | output | 1 | Completion pulse |
| sts_error | output | 1 | 1 = parameter error, 0 = success |
| sts_entry | output | 64 | Entry returned by a successful fetch |
| lst_req | output | 1 | List read request pulse |
| lst_addr | output | 64 | List read address |
| lst_rsp_valid | input | 1 | List read data present |
| lst_rsp_data | input | 64 | List read data, byte lane k = byte at offset k |
| evt_valid | output | 1 | Notification pulse |
| evt_map | output | 1 | 1 = mapping, 0 = unmapping |
| evt_iova | output | 64 | Window-relative page address |
| evt_paddr | output | 64 | Page part of the new entry |
| evt_mask | output | 64 | In-page offset mask |
| evt_perm | output | 2 | Permission bits of the new entry |

## Verification
The bench builds the engine with a 16-entry table, 4 KiB pages, a window base of 0x4000_0000 and table identifier 0x5A17. A fill that starts at index 14 therefore runs off the table end after two writes, and a list load of 513 pages is rejected by the page limit, not by the table size. The small table also keeps the reset clear short, so it can be counted edge by edge. List responses are returned after varying delays, which covers the wait in the fetch state.

// File: rtl/tce_cmd_pkg.sv
package tce_cmd_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_FILL  = 2'd2,
    OP_LOAD  = 2'd3
  } tce_op_e;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_CHECK,
    ST_STEP,
    ST_FETCH,
    ST_RDWAIT
  } tce_state_e;

  // byte lane k holds memory byte k; lane 0 becomes the most significant byte
  function automatic logic [63:0] lanes_to_entry(input logic [63:0] lanes);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*(7-b) +: 8] = lanes[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/tce_entry_ram.sv
module tce_entry_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/tce_page_index.sv
module tce_page_index #(
  parameter logic [63:0] BUS_OFFSET  = 64'h0,
  parameter int          PAGE_SHIFT  = 12,
  parameter int          ENTRY_COUNT = 64,
  parameter int          IW          = 6
) (
  input  logic [63:0]   page_addr,
  output logic [IW-1:0] index,
  output logic          out_of_range,
  output logic [63:0]   win_page
);

  logic [63:0] rel;
  logic [63:0] page_no;

  assign rel          = page_addr - BUS_OFFSET;
  assign page_no      = rel >> PAGE_SHIFT;
  assign out_of_range = page_no >= 64'(ENTRY_COUNT);
  assign index        = page_no[IW-1:0];
  assign win_page     = page_no << PAGE_SHIFT;

endmodule

// File: rtl/tce_event_fmt.sv
module tce_event_fmt #(
  parameter int PAGE_SHIFT = 12
) (
  input  logic [63:0] entry,
  output logic [63:0] page_addr,
  output logic [63:0] offset_mask,
  output logic [1:0]  perm,
  output logic        is_map
);

  localparam logic [63:0] LOW_MASK = (64'd1 << PAGE_SHIFT) - 64'd1;

  assign offset_mask = LOW_MASK;
  assign page_addr   = entry & ~LOW_MASK;
  assign perm        = entry[1:0];
  assign is_map      = |entry[1:0];

endmodule

// File: rtl/tce_update_engine.sv
module tce_update_engine
  import tce_cmd_pkg::*;
#(
  parameter logic [31:0] TABLE_ID         = 32'h0000_1000,
  parameter logic [63:0] BUS_OFFSET       = 64'h0,
  parameter int          PAGE_SHIFT       = 12,
  parameter int          ENTRY_COUNT      = 64,
  parameter int          LOAD_MAX_PAGES   = 512,
  parameter int          LIST_ALIGN_SHIFT = 12,
  parameter int          COUNT_W          = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [63:0]        cmd_table_id,
  input  logic [63:0]        cmd_bus_addr,
  input  logic [63:0]        cmd_value,
  input  logic [COUNT_W-1:0] cmd_pages,
  output logic               busy,
  output logic               sts_valid,
  output logic               sts_error,
  output logic [63:0]        sts_entry,
  output logic               lst_req,
  output logic [63:0]        lst_addr,
  input  logic               lst_rsp_valid,
  input  logic [63:0]        lst_rsp_data,
  output logic               evt_valid,
  output logic               evt_map,
  output logic [63:0]        evt_iova,
  output logic [63:0]        evt_paddr,
  output logic [63:0]        evt_mask,
  output logic [1:0]         evt_perm
);

  localparam int          IW          = (ENTRY_COUNT > 1) ? $clog2(ENTRY_COUNT) : 1;
  localparam logic [63:0] PAGE_BYTES  = 64'd1 << PAGE_SHIFT;
  localparam logic [63:0] OFS_MASK    = PAGE_BYTES - 64'd1;
  localparam logic [63:0] ENTRY_BYTES = 64'd8;

  tce_state_e         state_q, state_d;
  tce_op_e            op_q;
  logic               id_ok_q;
  logic [63:0]        addr_q;
  logic [63:0]        val_q;
  logic [COUNT_W-1:0] left_q;
  logic [IW-1:0]      clr_idx;

  logic [IW-1:0] cur_idx;
  logic          cur_oob;
  logic [63:0]   cur_win;

  logic          ram_we, ram_re;
  logic [IW-1:0] ram_waddr;
  logic [63:0]   ram_wdata, ram_rdata;

  logic [63:0] fmt_paddr, fmt_mask;
  logic [1:0]  fmt_perm;
  logic        fmt_map;

  logic        arg_bad, no_work, last, fin, fin_err, advance, evt_fire, fetch_go;
  logic [63:0] fin_data;

  tce_page_index #(
    .BUS_OFFSET (BUS_OFFSET),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ENTRY_COUNT(ENTRY_COUNT),
    .IW         (IW)
  ) u_index (
    .page_addr   (addr_q),
    .index       (cur_idx),
    .out_of_range(cur_oob),
    .win_page    (cur_win)
  );

  tce_entry_ram #(
    .DEPTH(ENTRY_COUNT),
    .WIDTH(64),
    .AW   (IW)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (ram_re),
    .raddr(cur_idx),
    .rdata(ram_rdata)
  );

  tce_event_fmt #(
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_fmt (
    .entry      (ram_wdata),
    .page_addr  (fmt_paddr),
    .offset_mask(fmt_mask),
    .perm       (fmt_perm),
    .is_map     (fmt_map)
  );

  assign busy = (state_q != ST_IDLE);
  assign last = (left_q == COUNT_W'(1));

  // argument screening done once, in the cycle after acceptance
  assign arg_bad = !id_ok_q
                || (op_q == OP_FILL && left_q > COUNT_W'(ENTRY_COUNT))
                || (op_q == OP_LOAD && (left_q > COUNT_W'(LOAD_MAX_PAGES)
                                        || val_q[LIST_ALIGN_SHIFT-1:0] != '0));
  assign no_work = (op_q == OP_FILL || op_q == OP_LOAD) && left_q == '0;

  // table port steering
  always_comb begin
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_waddr = cur_idx;
    ram_wdata = val_q;
    case (state_q)
      ST_CLEAR: begin
        ram_we    = 1'b1;
        ram_waddr = clr_idx;
        ram_wdata = '0;
      end
      ST_STEP: begin
        if (!cur_oob) begin
          if (op_q == OP_WRITE || op_q == OP_FILL) ram_we = 1'b1;
          if (op_q == OP_READ) ram_re = 1'b1;
        end
      end
      ST_FETCH: begin
        if (lst_rsp_valid) begin
          ram_we    = 1'b1;
          ram_wdata = lanes_to_entry(lst_rsp_data);
        end
      end
      default: ;
    endcase
  end

  assign evt_fire = ram_we && (state_q != ST_CLEAR);
  assign fetch_go = (state_q == ST_STEP) && !cur_oob && (op_q == OP_LOAD);

  // sequencing
  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_err  = 1'b0;
    fin_data = '0;
    advance  = 1'b0;
    case (state_q)
      ST_CLEAR:  if (clr_idx == IW'(ENTRY_COUNT - 1)) state_d = ST_IDLE;
      ST_IDLE:   if (cmd_valid) state_d = ST_CHECK;
      ST_CHECK: begin
        if (arg_bad) begin
          fin     = 1'b1;
          fin_err = 1'b1;
        end else if (no_work) begin
          fin = 1'b1;
        end else begin
          state_d = ST_STEP;
        end
      end
      ST_STEP: begin
        if (cur_oob) begin
          fin     = 1'b1;
          fin_err = 1'b1;
        end else begin
          case (op_q)
            OP_READ: state_d = ST_RDWAIT;
            OP_LOAD: state_d = ST_FETCH;
            default: begin
              advance = 1'b1;
              fin     = last;
            end
          endcase
        end
      end
      ST_FETCH: begin
        if (lst_rsp_valid) begin
          advance = 1'b1;
          if (last) fin = 1'b1;
          else      state_d = ST_STEP;
        end
      end
      ST_RDWAIT: begin
        fin      = 1'b1;
        fin_data = ram_rdata;
      end
      default: state_d = ST_CLEAR;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_CLEAR;
      op_q      <= OP_WRITE;
      id_ok_q   <= 1'b0;
      addr_q    <= '0;
      val_q     <= '0;
      left_q    <= '0;
      clr_idx   <= '0;
      sts_valid <= 1'b0;
      sts_error <= 1'b0;
      sts_entry <= '0;
      lst_req   <= 1'b0;
      lst_addr  <= '0;
      evt_valid <= 1'b0;
      evt_map   <= 1'b0;
      evt_iova  <= '0;
      evt_paddr <= '0;
      evt_mask  <= '0;
      evt_perm  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CLEAR) clr_idx <= clr_idx + IW'(1);
      if (state_q == ST_IDLE && cmd_valid) begin
        op_q    <= tce_op_e'(cmd_op);
        id_ok_q <= (cmd_table_id[63:32] == '0) && (cmd_table_id[31:0] == TABLE_ID);
        addr_q  <= cmd_bus_addr & ~OFS_MASK;
        val_q   <= cmd_value;
        left_q  <= (cmd_op == OP_WRITE || cmd_op == OP_READ) ? COUNT_W'(1) : cmd_pages;
      end
      if (advance) begin
        addr_q <= addr_q + PAGE_BYTES;
        left_q <= left_q - COUNT_W'(1);
      end
      if (state_q == ST_FETCH && lst_rsp_valid) val_q <= val_q + ENTRY_BYTES;
      sts_valid <= fin;
      if (fin) begin
        sts_error <= fin_err;
        sts_entry <= fin_data;
      end
      lst_req <= fetch_go;
      if (fetch_go) lst_addr <= val_q;
      evt_valid <= evt_fire;
      if (evt_fire) begin
        evt_map   <= fmt_map;
        evt_iova  <= cur_win;
        evt_paddr <= fmt_paddr;
        evt_mask  <= fmt_mask;
        evt_perm  <= fmt_perm;
      end
    end
  end

  // ---------------------------------------------------------------- checks
  assert_busy_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy);

  assert_status_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    sts_valid |=> !sts_valid);

  assert_no_event_on_error_R9: assert property (@(posedge clk) disable iff (rst)
    (sts_valid && sts_error) |-> !evt_valid);

  assert_event_page_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> ((evt_iova & evt_mask) == '0 && (evt_paddr & evt_mask) == '0));

  assert_list_fetch_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    lst_req |-> (lst_addr[2:0] == 3'b000 && busy));

  // R5: a fetch never shares a cycle with a table write
  assert_table_port_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));

endmodule

// File: tb/tb_tce_update_engine.sv
`timescale 1ns/1ps
module tb_tce_update_engine;

  localparam logic [31:0] TID  = 32'h0000_5A17;
  localparam logic [63:0] OFF  = 64'h0000_0000_4000_0000;
  localparam int          EC   = 16;
  localparam int          PSZ  = 4096;
  localparam logic [63:0] LOWM = 64'hFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [63:0] cmd_table_id = '0, cmd_bus_addr = '0, cmd_value = '0;
  logic [31:0] cmd_pages = '0;
  logic        busy, sts_valid, sts_error, lst_req, evt_valid, evt_map;
  logic [63:0] sts_entry, lst_addr, evt_iova, evt_paddr, evt_mask;
  logic [1:0]  evt_perm;
  logic        lst_rsp_valid = 1'b0;
  logic [63:0] lst_rsp_data = '0;

  always #10 clk = ~clk;

  tce_update_engine #(
    .TABLE_ID(TID), .BUS_OFFSET(OFF), .PAGE_SHIFT(12), .ENTRY_COUNT(EC),
    .LOAD_MAX_PAGES(512), .LIST_ALIGN_SHIFT(12), .COUNT_W(32)
  ) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_table_id(cmd_table_id), .cmd_bus_addr(cmd_bus_addr), .cmd_value(cmd_value),
    .cmd_pages(cmd_pages), .busy(busy), .sts_valid(sts_valid), .sts_error(sts_error),
    .sts_entry(sts_entry), .lst_req(lst_req), .lst_addr(lst_addr),
    .lst_rsp_valid(lst_rsp_valid), .lst_rsp_data(lst_rsp_data), .evt_valid(evt_valid),
    .evt_map(evt_map), .evt_iova(evt_iova), .evt_paddr(evt_paddr), .evt_mask(evt_mask),
    .evt_perm(evt_perm)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [63:0] model [EC];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock of comparison against the behavioural expectation
  task automatic tick(input string req, input bit e_busy, input bit e_sts, input bit e_err,
                      input logic [63:0] e_entry, input bit e_evt, input logic [63:0] e_iova,
                      input logic [63:0] e_val, input bit e_req, input logic [63:0] e_laddr);
    @(negedge clk);
    chk(busy == e_busy, req, "busy", 64'(busy), 64'(e_busy));
    chk(sts_valid == e_sts, req, "sts_valid", 64'(sts_valid), 64'(e_sts));
    if (e_sts) begin
      chk(sts_error == e_err, req, "sts_error", 64'(sts_error), 64'(e_err));
      chk(sts_entry == e_entry, req, "sts_entry", sts_entry, e_entry);
    end
    chk(evt_valid == e_evt, req, "evt_valid", 64'(evt_valid), 64'(e_evt));
    if (e_evt) begin
      chk(evt_iova == e_iova, req, "evt_iova", evt_iova, e_iova);
      chk(evt_paddr == (e_val & ~LOWM), req, "evt_paddr", evt_paddr, e_val & ~LOWM);
      chk(evt_mask == LOWM, req, "evt_mask", evt_mask, LOWM);
      chk(evt_perm == e_val[1:0], req, "evt_perm", 64'(evt_perm), 64'(e_val[1:0]));
      chk(evt_map == (e_val[1:0] != 2'b00), req, "evt_map", 64'(evt_map),
          64'(e_val[1:0] != 2'b00));
    end
    chk(lst_req == e_req, req, "lst_req", 64'(lst_req), 64'(e_req));
    if (e_req) chk(lst_addr == e_laddr, req, "lst_addr", lst_addr, e_laddr);
  endtask

  task automatic quiet(input string req);
    tick(req, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0);
  endtask

  function automatic logic [63:0] list_entry(input logic [63:0] a);
    return 64'h0000_00A5_0000_0000 | (a << 9) | 64'(a[4:3]);
  endfunction

  function automatic logic [63:0] to_lanes(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
    return r;
  endfunction

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < EC; i++) model[i] = '0;
    for (int i = 0; i < EC - 1; i++) quiet(req);
    tick(req, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0);
  endtask

  // drive one command and follow it cycle by cycle; spam keeps a store on cmd_valid while busy
  task automatic run_cmd(input string req, input logic [1:0] op, input logic [63:0] id,
                         input logic [63:0] addr, input logic [63:0] value,
                         input logic [31:0] pages, input int lat, input bit spam);
    bit bad;
    int n;
    logic [63:0] a, lp, rel, pg, v;
    cmd_valid = 1'b1; cmd_op = op; cmd_table_id = id; cmd_bus_addr = addr;
    cmd_value = value; cmd_pages = pages;
    bad = !(id[63:32] == '0 && id[31:0] == TID)
       || (op == 2'd2 && pages > 32'(EC))
       || (op == 2'd3 && (pages > 32'd512 || value[11:0] != '0));
    n = (op == 2'd0 || op == 2'd1) ? 1 : int'(pages);
    quiet(req);                       // checking cycle
    if (spam) begin
      cmd_op = 2'd0; cmd_table_id = 64'(TID); cmd_bus_addr = OFF + 64'(5 * PSZ);
      cmd_value = 64'hDEAD_B003;
    end else cmd_valid = 1'b0;
    if (bad || n == 0) begin
      cmd_valid = 1'b0;
      tick(req, 1'b0, 1'b1, bad, '0, 1'b0, '0, '0, 1'b0, '0);
      return;
    end
    quiet(req);                       // entering the first page step
    a  = addr & ~LOWM;
    lp = value;
    for (int i = 0; i < n; i++) begin
      rel = a - OFF;
      pg  = rel >> 12;
      if (pg >= 64'(EC)) begin
        cmd_valid = 1'b0;
        tick(req, 1'b0, 1'b1, 1'b1, '0, 1'b0, '0, '0, 1'b0, '0);
        return;
      end
      if (op == 2'd1) begin
        cmd_valid = 1'b0;
        quiet(req);
        tick(req, 1'b0, 1'b1, 1'b0, model[pg[3:0]], 1'b0, '0, '0, 1'b0, '0);
        return;
      end
      if (op == 2'd3) begin
        tick(req, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b1, lp);
        for (int d = 0; d < lat; d++) quiet(req);
        v = list_entry(lp);
        lst_rsp_valid = 1'b1;
        lst_rsp_data  = to_lanes(v);
      end else begin
        v = value;
      end
      model[pg[3:0]] = v;
      if (i == n - 1) cmd_valid = 1'b0;
      tick(req, i != n - 1, i == n - 1, 1'b0, '0, 1'b1, rel, v, 1'b0, '0);
      lst_rsp_valid = 1'b0;
      lst_rsp_data  = '0;
      a  = a + 64'(PSZ);
      lp = lp + 64'd8;
    end
  endtask

  task automatic rd(input string req, input int idx);
    run_cmd(req, 2'd1, 64'(TID), OFF + 64'(idx * PSZ), '0, 32'd0, 0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: clear after reset
    do_reset("R1");
    rd("R1", 3);
    // R4 R3 R6: store with unaligned address, mapping event
    run_cmd("R4", 2'd0, 64'(TID), OFF + 64'(2 * PSZ) + 64'h123, 64'h0000_0000_8765_4003, 32'd77, 0, 1'b0);
    rd("R5", 2);
    // R6: permission zero is an unmapping
    run_cmd("R6", 2'd0, 64'(TID), OFF + 64'(7 * PSZ), 64'h0000_0001_2345_6000, 32'd0, 0, 1'b0);
    run_cmd("R6", 2'd0, 64'(TID), OFF + 64'(9 * PSZ), 64'h0000_0002_0000_1001, 32'd0, 0, 1'b0);
    // R2: identifier screening
    run_cmd("R2", 2'd0, 64'h0000_0001_0000_5A17, OFF, 64'h1111_1003, 32'd0, 0, 1'b0);
    run_cmd("R2", 2'd0, 64'h0000_0000_0000_5A18, OFF, 64'h1111_1003, 32'd0, 0, 1'b0);
    run_cmd("R2", 2'd2, 64'h8000_0000_0000_5A17, OFF, 64'h1111_1003, 32'd2, 0, 1'b0);
    rd("R2", 0);
    // R3 R5: out-of-range indices
    run_cmd("R3", 2'd0, 64'(TID), OFF - 64'(PSZ), 64'h2222_2003, 32'd0, 0, 1'b0);
    run_cmd("R3", 2'd0, 64'(TID), OFF + 64'(EC * PSZ), 64'h2222_2003, 32'd0, 0, 1'b0);
    run_cmd("R5", 2'd1, 64'(TID), OFF + 64'(EC * PSZ), '0, 32'd0, 0, 1'b0);
    rd("R3", 15);
    // R7: fill limits and a full-table fill with cmd_valid held while busy (R11)
    run_cmd("R7", 2'd2, 64'(TID), OFF, 64'h3333_3002, 32'(EC + 1), 0, 1'b0);
    run_cmd("R11", 2'd2, 64'(TID), OFF, 64'h0000_0000_3333_3002, 32'(EC), 0, 1'b1);
    rd("R11", 5);
    rd("R7", 15);
    // R9: fill runs off the table end
    run_cmd("R9", 2'd2, 64'(TID), OFF + 64'(14 * PSZ), 64'h0000_0000_4444_4001, 32'd4, 0, 1'b0);
    rd("R9", 15);
    rd("R9", 13);
    // R10: zero page counts
    run_cmd("R10", 2'd2, 64'(TID), OFF, 64'h5555_5003, 32'd0, 0, 1'b0);
    run_cmd("R10", 2'd3, 64'(TID), OFF, 64'h0010_0000, 32'd0, 0, 1'b0);
    // R8: list load screening and loads with varied response delay
    run_cmd("R8", 2'd3, 64'(TID), OFF, 64'h0010_0000, 32'd513, 0, 1'b0);
    run_cmd("R8", 2'd3, 64'(TID), OFF, 64'h0010_0008, 32'd2, 0, 1'b0);
    run_cmd("R8", 2'd3, 64'(TID), OFF + 64'(4 * PSZ), 64'h0010_0000, 32'd4, 2, 1'b0);
    run_cmd("R8", 2'd3, 64'(TID), OFF + 64'(1 * PSZ), 64'h0020_0000, 32'd2, 0, 1'b0);
    rd("R8", 6);
    // R9: list load stops at the table end
    run_cmd("R9", 2'd3, 64'(TID), OFF + 64'(13 * PSZ), 64'h0030_0000, 32'd5, 1, 1'b0);
    rd("R9", 14);
    // R1: a second reset clears written entries
    do_reset("R1");
    rd("R1", 13);
    rd("R1", 4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule